// File: doc/BRIEF.md
# LED Matrix Controller Command Register Bank

This block sits behind a two-wire serial slave front end and turns the received byte stream into the configuration and display state of a 16x8 LED matrix controller. The front end reports transaction start and stop, strobes each received byte, and asks for a byte whenever the host reads. The first byte of every transaction is a command. Its upper nibble selects which register it targets. Address commands set a byte pointer. Later bytes in a write transaction then land in a 16-byte display memory, and the pointer steps forward after each one.

Reads return the byte at the pointer and then step the pointer. The pointer can reach display memory, six bytes of key-matrix data supplied by a separate scanner, and a key-event flag. When a read goes past the last key byte, the block sends the scanner a one-cycle pulse so that the scanner can clear its key data and flag. In standby, only the system command is obeyed: every other command and every display-memory write is dropped. A grid-select input gives the drive logic the 16 segment bits of any grid.

Top module: `ledctl_cmd_bank`

## Requirements
- R1: After reset the oscillator-enable, display-enable, blink code, interrupt-pin enable and interrupt polarity outputs are all 0, the brightness level is 15, the pointer is 0x00 and every display-memory byte reads 0x00.
- R2: A first byte whose upper nibble is 0x2 copies its bit 0 to `osc_on` (1 = normal, 0 = standby). It is accepted in any mode.
- R3: A first byte whose upper nibble is 0x8 sets `disp_on` from bit 0 and `blink_sel` from bits 2:1, where 00 = off, 01 = 2 Hz, 10 = 1 Hz and 11 = 0.5 Hz.
- R4: A first byte whose upper nibble is 0xA sets `int_pin_en` from bit 0 (1 = shared pin is the interrupt output) and `int_active_high` from bit 1.
- R5: A first byte whose upper nibble is 0xE sets `bright_level` to bits 3:0. Level n means a grid duty of (n+1)/16.
- R6: A first byte whose upper nibble is 0x0 loads the pointer with bits 3:0. Each following byte of the same transaction is written to display memory at the pointer, and the pointer then steps forward, wrapping from 0x0F to 0x00.
- R7: For grid g, `grid_segs` equals {byte 2g+1, byte 2g}. Bit 0 of byte 2g is the lowest segment.
- R8: Each read request returns the byte at the pointer on `tx_data` in the same cycle, and the pointer steps at the following clock edge. Inside display memory the step wraps from 0x0F to 0x00.
- R9: A first byte of 0x4X or 0x6X loads the whole byte into the pointer. Reading 0x40+i (i = 0..5) returns `key_bytes[8i+7:8i]`. Reading 0x60 returns 0xFF while `key_pending` is 1 and 0x00 otherwise. Any other address outside display memory returns 0x00.
- R10: `scan_read_done` is 1 for exactly the one cycle after a read at address 0x45, and is 0 otherwise.
- R11: While `osc_on` is 0, display, pin, brightness and address commands change nothing, and no display-memory byte is written.
- R12: Only the first byte after a start is decoded as a command. A later byte in a transaction that did not begin with a 0x0X address command changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | Transaction start or repeated start, one cycle |
| bus_stop | input | 1 | Transaction stop, one cycle |
| rx_valid | input | 1 | Received-byte strobe |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | Host read of one byte; pointer steps at the edge |
| tx_data | output | 8 | Byte at the pointer |
| key_bytes | input | KEY_BYTES*8 | Key matrix data from the scanner |
| key_pending | input | 1 | Scanner has an unread key event |
| scan_read_done | output | 1 | Pulse: key data fully read |
| osc_on | output | 1 | Normal mode (1) or standby (0) |
| disp_on | output | 1 | Display enable |
| blink_sel | output | 2 | Blink rate code |
| int_pin_en | output | 1 | Shared pin acts as interrupt output |
| int_active_high | output | 1 | Interrupt level polarity |
| bright_level | output | 4 | Duty level, (n+1)/16 |
| grid_sel | input | GRID_SEL_W | Grid to view |
| grid_segs | output | 16 | Segment bits of the selected grid |

## Verification
A corrupted pointer is visible at the very next read: `tx_data` shows the wrong byte in the cycle of the request. Every later byte of the burst is shifted as well, and the done pulse appears at the wrong read or not at all. A lost or misplaced display-memory write appears on `grid_segs` as soon as the bench sweeps the grids after the burst. A configuration register that wrongly takes a command in standby, or from a non-first byte, shows up on the configuration outputs one cycle after the byte. Random bursts cross the 0x0F wrap and the standby transitions many times, with directed cases for the key region, the flag and the done pulse.

// File: rtl/ledctl_pkg.sv
// Shared command codes and configuration type for the LED command bank.
package ledctl_pkg;

    localparam logic [3:0] OP_ADDR   = 4'h0;
    localparam logic [3:0] OP_SYS    = 4'h2;
    localparam logic [3:0] OP_KEYPTR = 4'h4;
    localparam logic [3:0] OP_FLGPTR = 4'h6;
    localparam logic [3:0] OP_DISP   = 4'h8;
    localparam logic [3:0] OP_PIN    = 4'hA;
    localparam logic [3:0] OP_BRIGHT = 4'hE;

    typedef enum logic [1:0] {
        BLINK_OFF  = 2'b00,
        BLINK_2HZ  = 2'b01,
        BLINK_1HZ  = 2'b10,
        BLINK_HALF = 2'b11
    } blink_e;

    typedef struct packed {
        logic       osc_on;
        logic       disp_on;
        blink_e     blink;
        logic       int_en;
        logic       int_hi;
        logic [3:0] bright;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        osc_on:  1'b0,
        disp_on: 1'b0,
        blink:   BLINK_OFF,
        int_en:  1'b0,
        int_hi:  1'b0,
        bright:  4'hF
    };

endpackage

// File: rtl/ledctl_cmd_decode.sv
// Command decoder and configuration registers.
// Decodes the first byte after each start and holds the system, display, pin
// and brightness settings. It flags which later bytes are display writes.
// Assumes that start, stop and byte strobes never coincide.
module ledctl_cmd_decode
    import ledctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output cfg_t       cfg,
    output logic       ptr_load,
    output logic [7:0] ptr_load_val,
    output logic       ram_wr
);

    logic       first_q;
    logic       wr_act_q;
    logic [3:0] op;
    logic       cmd_seen;

    assign op       = rx_data[7:4];
    assign cmd_seen = rx_valid && first_q;

    // Pointer load request: any address command, obeyed only in normal mode.
    assign ptr_load     = cmd_seen && cfg.osc_on &&
                          (op == OP_ADDR || op == OP_KEYPTR || op == OP_FLGPTR);
    assign ptr_load_val = (op == OP_ADDR) ? {4'h0, rx_data[3:0]} : rx_data;

    // Display write strobe: a data byte inside a write-enabled transaction.
    assign ram_wr = rx_valid && !first_q && wr_act_q;

    // Transaction tracking and command register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= CFG_RESET;
            first_q  <= 1'b0;
            wr_act_q <= 1'b0;
        end else if (bus_start) begin
            first_q  <= 1'b1;
            wr_act_q <= 1'b0;
        end else if (bus_stop) begin
            first_q  <= 1'b0;
            wr_act_q <= 1'b0;
        end else if (cmd_seen) begin
            first_q  <= 1'b0;
            wr_act_q <= (op == OP_ADDR) && cfg.osc_on;
            if (op == OP_SYS) begin
                cfg.osc_on <= rx_data[0];
            end else if (cfg.osc_on) begin
                case (op)
                    OP_DISP: begin
                        cfg.disp_on <= rx_data[0];
                        cfg.blink   <= blink_e'(rx_data[2:1]);
                    end
                    OP_PIN: begin
                        cfg.int_en <= rx_data[0];
                        cfg.int_hi <= rx_data[1];
                    end
                    OP_BRIGHT: cfg.bright <= rx_data[3:0];
                    default: ;
                endcase
            end
        end
    end

    // R2
    sys_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_seen && op == OP_SYS && !bus_start && !bus_stop)
        |=> cfg.osc_on == $past(rx_data[0]));

    // R11
    standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.osc_on && rx_valid && op != OP_SYS)
        |=> $stable({cfg.disp_on, cfg.blink, cfg.int_en, cfg.int_hi, cfg.bright}));

    // R12
    data_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !first_q && !bus_start) |=> $stable(cfg));

endmodule

// File: rtl/ledctl_ptr.sv
// Byte pointer with auto-increment.
// Load has priority over the write step, and the write step over the read step.
// Inside display memory the pointer wraps at the memory size; elsewhere it
// simply counts up.
module ledctl_ptr #(
    parameter int RAM_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       wr_step,
    input  logic       rd_step,
    output logic [7:0] ptr
);

    localparam logic [7:0] RAM_LAST = 8'(RAM_BYTES - 1);

    logic [7:0] step_val;

    // Next address after one step, wrapping inside display memory.
    always_comb begin
        if (ptr == RAM_LAST)      step_val = 8'h00;
        else                      step_val = ptr + 8'h01;
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ptr <= 8'h00;
        else if (load)               ptr <= load_val;
        else if (wr_step || rd_step) ptr <= step_val;
    end

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step && !load && ptr == RAM_LAST) |=> ptr == 8'h00);

endmodule

// File: rtl/ledctl_disp_ram.sv
// Display memory: byte array, cleared at reset.
// One write port, one read port for the host and one grid view for the drive
// logic. Grid g is made of bytes 2g (low segments) and 2g+1 (high segments).
module ledctl_disp_ram #(
    parameter int RAM_BYTES  = 16,
    parameter int ADDR_W     = $clog2(RAM_BYTES),
    parameter int GRID_SEL_W = $clog2(RAM_BYTES / 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [7:0]            rd_data,
    input  logic [GRID_SEL_W-1:0] grid_sel,
    output logic [15:0]           grid_segs
);

    localparam int GRIDS = RAM_BYTES / 2;

    logic [7:0]  mem   [RAM_BYTES];
    logic [15:0] grid_w[GRIDS];

    // Storage with reset clear and byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_BYTES; i++) mem[i] <= 8'h00;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Host read port.
    assign rd_data = mem[rd_addr];

    // Pair bytes into per-grid segment words.
    for (genvar g = 0; g < GRIDS; g++) begin : g_grid
        assign grid_w[g] = {mem[2*g+1], mem[2*g]};
    end

    // Grid view for the drive logic.
    assign grid_segs = grid_w[grid_sel];

endmodule

// File: rtl/ledctl_read_mux.sv
// Read data selection and key-read completion pulse.
// Maps the pointer onto display memory, key bytes, the key flag, or zero.
// Registers a one-cycle pulse after the last key byte has been read.
module ledctl_read_mux #(
    parameter int         RAM_BYTES = 16,
    parameter int         KEY_BYTES = 6,
    parameter logic [7:0] KEY_BASE  = 8'h40,
    parameter logic [7:0] FLAG_ADDR = 8'h60
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             ptr,
    input  logic                   tx_req,
    input  logic [7:0]             ram_rd_data,
    input  logic [KEY_BYTES*8-1:0] key_bytes,
    input  logic                   key_pending,
    output logic [7:0]             tx_data,
    output logic                   read_done
);

    localparam logic [7:0] KEY_LAST = 8'(KEY_BASE + 8'(KEY_BYTES - 1));

    logic in_ram;

    assign in_ram = (ptr < 8'(RAM_BYTES));

    // Byte selection by address region.
    always_comb begin
        tx_data = 8'h00;
        if (in_ram) begin
            tx_data = ram_rd_data;
        end else if (ptr == FLAG_ADDR) begin
            tx_data = {8{key_pending}};
        end else begin
            for (int i = 0; i < KEY_BYTES; i++) begin
                if (ptr == 8'(KEY_BASE + 8'(i))) tx_data = key_bytes[i*8 +: 8];
            end
        end
    end

    // Completion pulse toward the key scanner.
    always_ff @(posedge clk) begin
        if (!rst_n) read_done <= 1'b0;
        else        read_done <= tx_req && (ptr == KEY_LAST);
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        read_done |=> !read_done);

    // R9
    flag_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == FLAG_ADDR) |-> (tx_data == (key_pending ? 8'hFF : 8'h00)));

endmodule

// File: rtl/ledctl_cmd_bank.sv
// Command register bank of a 16x8 LED matrix controller.
// Takes byte events from a serial slave front end and holds the configuration
// registers and display memory. It serves reads of memory, key data and the
// key flag. Assumes that the front end never asserts two events in one cycle.
module ledctl_cmd_bank
    import ledctl_pkg::*;
#(
    parameter int         RAM_BYTES  = 16,
    parameter int         KEY_BYTES  = 6,
    parameter logic [7:0] KEY_BASE   = 8'h40,
    parameter logic [7:0] FLAG_ADDR  = 8'h60,
    parameter int         GRID_SEL_W = $clog2(RAM_BYTES / 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_start,
    input  logic                   bus_stop,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_data,
    input  logic                   tx_req,
    output logic [7:0]             tx_data,
    input  logic [KEY_BYTES*8-1:0] key_bytes,
    input  logic                   key_pending,
    output logic                   scan_read_done,
    output logic                   osc_on,
    output logic                   disp_on,
    output logic [1:0]             blink_sel,
    output logic                   int_pin_en,
    output logic                   int_active_high,
    output logic [3:0]             bright_level,
    input  logic [GRID_SEL_W-1:0]  grid_sel,
    output logic [15:0]            grid_segs
);

    localparam int ADDR_W = $clog2(RAM_BYTES);

    cfg_t       cfg;
    logic       ptr_load;
    logic [7:0] ptr_load_val;
    logic       ram_wr;
    logic [7:0] ptr;
    logic [7:0] ram_rd_data;

    ledctl_cmd_decode u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_start    (bus_start),
        .bus_stop     (bus_stop),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .cfg          (cfg),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ram_wr       (ram_wr)
    );

    ledctl_ptr #(.RAM_BYTES(RAM_BYTES)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .wr_step  (ram_wr),
        .rd_step  (tx_req),
        .ptr      (ptr)
    );

    ledctl_disp_ram #(
        .RAM_BYTES  (RAM_BYTES),
        .ADDR_W     (ADDR_W),
        .GRID_SEL_W (GRID_SEL_W)
    ) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ram_wr),
        .wr_addr   (ptr[ADDR_W-1:0]),
        .wr_data   (rx_data),
        .rd_addr   (ptr[ADDR_W-1:0]),
        .rd_data   (ram_rd_data),
        .grid_sel  (grid_sel),
        .grid_segs (grid_segs)
    );

    ledctl_read_mux #(
        .RAM_BYTES (RAM_BYTES),
        .KEY_BYTES (KEY_BYTES),
        .KEY_BASE  (KEY_BASE),
        .FLAG_ADDR (FLAG_ADDR)
    ) u_rmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr         (ptr),
        .tx_req      (tx_req),
        .ram_rd_data (ram_rd_data),
        .key_bytes   (key_bytes),
        .key_pending (key_pending),
        .tx_data     (tx_data),
        .read_done   (scan_read_done)
    );

    // Configuration outputs.
    assign osc_on          = cfg.osc_on;
    assign disp_on         = cfg.disp_on;
    assign blink_sel       = cfg.blink;
    assign int_pin_en      = cfg.int_en;
    assign int_active_high = cfg.int_hi;
    assign bright_level    = cfg.bright;

    // R11
    standby_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_on |-> !ram_wr);

endmodule

// File: tb/ledctl_cmd_bank_bench.sv
`timescale 1ns/1ps
module ledctl_cmd_bank_bench;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_start = 0, bus_stop = 0, rx_valid = 0, tx_req = 0;
    logic [7:0]  rx_data = 0;
    logic [7:0]  tx_data;
    logic [47:0] key_bytes = 0;
    logic        key_pending = 0;
    logic        scan_read_done, osc_on, disp_on, int_pin_en, int_active_high;
    logic [1:0]  blink_sel;
    logic [3:0]  bright_level;
    logic [2:0]  grid_sel = 0;
    logic [15:0] grid_segs;

    always #10 clk = ~clk;

    ledctl_cmd_bank u_ledctl_cmd_bank (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_req(tx_req), .tx_data(tx_data),
        .key_bytes(key_bytes), .key_pending(key_pending),
        .scan_read_done(scan_read_done), .osc_on(osc_on), .disp_on(disp_on),
        .blink_sel(blink_sel), .int_pin_en(int_pin_en),
        .int_active_high(int_active_high), .bright_level(bright_level),
        .grid_sel(grid_sel), .grid_segs(grid_segs)
    );

    int checks = 0, fails = 0;
    bit done_flag = 0;

    // Reference model state
    logic [7:0] m_ram [16];
    logic [7:0] m_ptr;
    logic       e_osc, e_disp, e_int_en, e_int_hi;
    logic [1:0] e_blink;
    logic [3:0] e_bright;

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] nxt(input logic [7:0] p);
        return (p == 8'h0F) ? 8'h00 : p + 8'h01;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] p);
        if (p < 8'h10) return m_ram[p[3:0]];
        if (p == 8'h60) return {8{key_pending}};
        if (p >= 8'h40 && p <= 8'h45) return key_bytes[(p - 8'h40) * 8 +: 8];
        return 8'h00;
    endfunction

    // Model of a first (command) byte; returns 1 if it opens a write burst.
    function automatic bit model_cmd(input logic [7:0] b);
        if (b[7:4] == 4'h2) begin e_osc = b[0]; return 0; end
        if (!e_osc) return 0;
        case (b[7:4])
            4'h8: begin e_disp = b[0]; e_blink = b[2:1]; end
            4'hA: begin e_int_en = b[0]; e_int_hi = b[1]; end
            4'hE: e_bright = b[3:0];
            4'h0: begin m_ptr = {4'h0, b[3:0]}; return 1; end
            4'h4, 4'h6: m_ptr = b;
            default: ;
        endcase
        return 0;
    endfunction

    task automatic pstart; @(negedge clk) bus_start = 1; @(negedge clk) bus_start = 0; endtask
    task automatic pstop;  @(negedge clk) bus_stop = 1;  @(negedge clk) bus_stop = 0;  endtask
    task automatic send(input logic [7:0] b);
        @(negedge clk) begin rx_valid = 1; rx_data = b; end
        @(negedge clk) rx_valid = 0;
    endtask

    task automatic check_cfg(input string tag);
        chk(osc_on == e_osc, {tag, " R2 osc_on"}, osc_on, e_osc);
        chk({disp_on, blink_sel} == {e_disp, e_blink}, {tag, " R3 disp/blink"},
            {disp_on, blink_sel}, {e_disp, e_blink});
        chk({int_pin_en, int_active_high} == {e_int_en, e_int_hi}, {tag, " R4 pin"},
            {int_pin_en, int_active_high}, {e_int_en, e_int_hi});
        chk(bright_level == e_bright, {tag, " R5 bright"}, bright_level, e_bright);
    endtask

    task automatic do_cmd(input logic [7:0] b, input string tag);
        bit w;
        pstart; send(b); pstop;
        w = model_cmd(b);
        check_cfg(tag);
    endtask

    task automatic do_write(input logic [7:0] a, input int n);
        bit w;
        pstart; send(a);
        w = model_cmd(a);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = 8'($urandom);
            send(d);
            if (w) begin m_ram[m_ptr[3:0]] = d; m_ptr = nxt(m_ptr); end
        end
        pstop;
    endtask

    task automatic do_read(input logic [7:0] a, input int n, input string tag);
        bit w;
        logic [7:0] v, e;
        pstart; send(a);
        w = model_cmd(a);
        pstart;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tx_req = 1;
            #2 v = tx_data;
            e = exp_rd(m_ptr);
            chk(v == e, {tag, " R8/R9 read data"}, v, e);
            @(negedge clk) tx_req = 0;
            chk(scan_read_done == (m_ptr == 8'h45), {tag, " R10 done pulse"},
                scan_read_done, (m_ptr == 8'h45));
            m_ptr = nxt(m_ptr);
        end
        @(negedge clk) chk(scan_read_done == 0, {tag, " R10 pulse one cycle"}, scan_read_done, 0);
        pstop;
    endtask

    task automatic check_grids(input string tag);
        for (int g = 0; g < 8; g++) begin
            @(negedge clk) grid_sel = 3'(g);
            #1 chk(grid_segs == {m_ram[2*g+1], m_ram[2*g]}, {tag, " R7 grid map"},
                   grid_segs, {m_ram[2*g+1], m_ram[2*g]});
        end
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 16; i++) m_ram[i] = 8'h00;
        m_ptr = 0; e_osc = 0; e_disp = 0; e_blink = 0; e_int_en = 0; e_int_hi = 0; e_bright = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_cfg("R1 reset");
        check_grids("R1 reset");
        @(negedge clk) tx_req = 1;
        #2 chk(tx_data == 8'h00, "R1 pointer/memory reset", tx_data, 0);
        @(negedge clk) tx_req = 0; m_ptr = nxt(m_ptr);
        // R11 standby ignores commands and writes
        do_cmd(8'h87, "R11 standby disp");
        do_cmd(8'hE3, "R11 standby bright");
        do_cmd(8'hA3, "R11 standby pin");
        do_write(8'h05, 3);
        check_grids("R11 standby write");
        do_read(8'h09, 2, "R11 standby addr");
        // R2 wake up
        do_cmd(8'h21, "R2 wake");
        // R3 blink codes
        for (int k = 0; k < 8; k++) do_cmd(8'h80 | 8'(k), "R3 display");
        do_cmd(8'hA1, "R4 int low");
        do_cmd(8'hA3, "R4 int high");
        do_cmd(8'hE0, "R5 min");
        do_cmd(8'hE9, "R5 mid");
        // R6 wrap during write
        do_write(8'h0D, 6);
        check_grids("R6 wrap");
        do_read(8'h0E, 5, "R8 wrap read");
        // R12 non-first byte ignored
        pstart; send(8'hE2); send(8'h81); send(8'h05); pstop;
        begin bit w; w = model_cmd(8'hE2); end
        check_cfg("R12 later byte");
        check_grids("R12 later byte");
        // R9/R10 key region and flag
        key_bytes = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
        do_read(8'h40, 7, "R9 keys");
        key_pending = 1;
        do_read(8'h60, 2, "R9 flag set");
        key_pending = 0;
        do_read(8'h60, 1, "R9 flag clear");
        do_read(8'h43, 3, "R10 partial key read");
        // Random mix
        for (int it = 0; it < 120; it++) begin
            int sel = int'($urandom_range(0, 5));
            case (sel)
                0: do_write({4'h0, 4'($urandom)}, int'($urandom_range(1, 20)));
                1: do_read({4'h0, 4'($urandom)}, int'($urandom_range(1, 20)), "R8 rand");
                2: do_cmd(($urandom_range(0, 3) == 0) ? 8'h20 : 8'h21, "R2 rand");
                3: begin
                    logic [7:0] ops [3] = '{8'h80, 8'hA0, 8'hE0};
                    do_cmd(ops[$urandom_range(0, 2)] | 8'($urandom_range(0, 15)), "R3-5 rand");
                end
                4: check_grids("R7 rand");
                default: begin
                    key_bytes = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
                    key_pending = 1'($urandom);
                    do_read(($urandom_range(0, 1) != 0) ? 8'h40 : 8'h60,
                            int'($urandom_range(1, 7)), "R9 rand");
                end
            endcase
        end
        finish_run;
    end

endmodule